// File: doc/BRIEF.md
# Three-Channel Colour Matrix Transform

This block converts three parallel colour channels into three new channels by multiplying them with a 3x3 coefficient matrix. Every output is the sum of the three inputs, each weighted by its own coefficient, so nine multipliers work in parallel. Each multiplier has a small bank of coefficient sets. A shared set index, sampled with the data, picks the same set in all nine banks. The set can change on every clock, so different pixels in a stream can use different matrices.

For each output, the three products are summed and the low bits are dropped, giving a 20-bit intermediate. A rounding and saturation stage then takes a 13-bit window from that intermediate, with a programmable position. It rounds half up at the bit below the window and clamps the result to the signed 13-bit range. A simple write port loads the coefficient banks. With unit coefficients on the diagonal and the window at position 3, samples pass through unchanged.

Top module: `color_matrix_xform`

## Requirements
- R1: An asserted `rst_n` (active low, asynchronous) clears every coefficient and every pipeline stage. After `rst_n` is released, all three outputs read zero for the first five clock edges.
- R2: Coefficient `K[r][c][s]` multiplies input channel c (a=0, b=1, c=2) for output r under set s. Let `M = floor((sum over c of x_c * K[r][c][s]) / 256)`. M is the 20-bit signed intermediate for output r. All inputs of zero give zero outputs.
- R3: Coefficients are 13-bit two's complement with 11 fractional bits: 0x0800 is +1.0, 0x0400 is +0.5 and 0x1800 is -1.0. With unit coefficients on the diagonal and `win_lsb` = 3, each output equals its input.
- R4: When `cfg_we` is high at a rising edge, `cfg_wdata` is written to bank `cfg_addr[5:2]` (bank number r*3+c) at set `cfg_addr[1:0]`. When `cfg_we` is low, no coefficient changes.
- R5: A write that addresses bank 9 through 15 changes no coefficient.
- R6: `set_sel` is sampled together with the inputs in the same cycle. It selects set 0 to 3 in all nine banks for those samples only, and may differ on every cycle.
- R7: An input sampled at rising edge k appears on the outputs after rising edge k+5, which is six register stages. A new result is produced on every clock.
- R8: The output is `floor((M + H) / 2^w)`, where w = `win_lsb` (0 to 7). H is 2^(w-1) for w > 0 and 0 for w = 0. This rounds half toward plus infinity.
- R9: Results above 4095 are output as 4095. Results below -4096 are output as -4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_sel | input | 2 | Coefficient set used by this cycle's samples |
| in_a | input | 13 | Input channel 0, signed |
| in_b | input | 13 | Input channel 1, signed |
| in_c | input | 13 | Input channel 2, signed |
| win_lsb | input | 3 | Bit position of the output window inside the intermediate; hold steady while data flows |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 6 | Coefficient address: bank in [5:2], set in [1:0] |
| cfg_wdata | input | 13 | Coefficient value, signed with 11 fractional bits |
| out_a | output | 13 | Output channel 0, signed |
| out_b | output | 13 | Output channel 1, signed |
| out_c | output | 13 | Output channel 2, signed |

## Verification
The bench uses the default parameters: 13-bit data and coefficients, a 20-bit intermediate, four sets and a 3-bit window field. These widths let hand-derived values reach every case that matters. The cases are exact pass-through, a channel permutation, half-weight sums whose rounding lands on ties of both signs, and negated full-scale inputs that saturate in both directions. The window field spans 0 to 7, so both a magnified output that clips and a strongly reduced output that rounds up can be checked. The set index changes on every cycle of the vector stream, which exposes any skew between the index and its data.

// File: rtl/cmx_pkg.sv
`timescale 1ns/1ps
package cmx_pkg;
    // Number of colour channels handled side by side.
    localparam int unsigned CMX_NCH   = 3;
    // One coefficient bank per (output row, input column) pair.
    localparam int unsigned CMX_NBANK = CMX_NCH * CMX_NCH;

    // Flat bank number for output row r fed by input column c.
    function automatic int unsigned cmx_bank_of(input int unsigned r, input int unsigned c);
        return r * CMX_NCH + c;
    endfunction
endpackage

// File: rtl/cmx_coef_store.sv
`timescale 1ns/1ps
module cmx_coef_store #(
    parameter int unsigned COEF_W = 13,
    parameter int unsigned NSETS  = 4,
    parameter int unsigned NBANK  = 9,
    parameter int unsigned BIDX_W = 4,
    parameter int unsigned SEL_W  = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      we_i,
    input  logic [BIDX_W-1:0]                         bidx_i,
    input  logic [SEL_W-1:0]                          set_i,
    input  logic [COEF_W-1:0]                         wdata_i,
    output logic [NBANK-1:0][NSETS-1:0][COEF_W-1:0]   store_o
);
    typedef struct packed {
        logic [NBANK-1:0][NSETS-1:0][COEF_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Decode only the banks that exist; higher indices fall through.
        for (int b = 0; b < int'(NBANK); b++) begin
            if (we_i && (bidx_i == BIDX_W'(b))) begin
                st_d.mem[b][set_i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store_o = st_q.mem;
endmodule

// File: rtl/cmx_dot3.sv
`timescale 1ns/1ps
module cmx_dot3 #(
    parameter int unsigned DATA_W = 13,
    parameter int unsigned COEF_W = 13,
    parameter int unsigned MID_W  = 20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [2:0][DATA_W-1:0]        x_i,
    input  logic [2:0][COEF_W-1:0]        k_i,
    output logic [MID_W-1:0]              mid_o
);
    localparam int unsigned PROD_W = DATA_W + COEF_W;
    localparam int unsigned SUM_W  = PROD_W + 2;
    localparam int unsigned DROP   = SUM_W - MID_W;

    typedef struct packed {
        logic [2:0][PROD_W-1:0] prod;   // stage 3
        logic [MID_W-1:0]       mid;    // stage 4
    } dot_t;

    dot_t st_d, st_q;

    logic signed [PROD_W-1:0] xs, ks, pr;
    logic signed [SUM_W-1:0]  acc;

    always_comb begin
        st_d = st_q;
        xs   = '0;
        ks   = '0;
        pr   = '0;
        for (int c = 0; c < 3; c++) begin
            xs = PROD_W'($signed(x_i[c]));
            ks = PROD_W'($signed(k_i[c]));
            pr = xs * ks;
            st_d.prod[c] = pr;
        end
        acc = '0;
        for (int c = 0; c < 3; c++) begin
            acc = acc + SUM_W'($signed(st_q.prod[c]));
        end
        // Keep the upper bits: an arithmetic floor by 2^DROP.
        st_d.mid = acc[SUM_W-1:DROP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mid_o = st_q.mid;
endmodule

// File: rtl/cmx_rsl.sv
`timescale 1ns/1ps
module cmx_rsl #(
    parameter int unsigned MID_W  = 20,
    parameter int unsigned DATA_W = 13,
    parameter int unsigned WIN_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MID_W-1:0]     mid_i,
    input  logic [WIN_W-1:0]     win_i,
    output logic [DATA_W-1:0]    res_o
);
    localparam int unsigned EXT_W = MID_W + 1;
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

    typedef struct packed {
        logic [EXT_W-1:0]  rnd;   // stage 5: windowed and rounded
        logic [DATA_W-1:0] res;   // stage 6: saturated
    } rsl_t;

    rsl_t st_d, st_q;

    logic signed [EXT_W-1:0] ext, half, shifted, held;

    always_comb begin
        st_d    = st_q;
        ext     = EXT_W'($signed(mid_i));
        half    = (win_i == '0) ? '0 : (EXT_W'(1) <<< (win_i - WIN_W'(1)));
        shifted = (ext + half) >>> win_i;
        st_d.rnd = shifted;

        held = $signed(st_q.rnd);
        if (held > MAXV)      st_d.res = MAXV[DATA_W-1:0];
        else if (held < MINV) st_d.res = MINV[DATA_W-1:0];
        else                  st_d.res = held[DATA_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;
endmodule

// File: rtl/color_matrix_xform.sv
`timescale 1ns/1ps
module color_matrix_xform
    import cmx_pkg::*;
#(
    parameter int unsigned DATA_W = 13,
    parameter int unsigned COEF_W = 13,
    parameter int unsigned MID_W  = 20,
    parameter int unsigned NSETS  = 4,
    parameter int unsigned WIN_W  = 3,
    parameter int unsigned BIDX_W = 4,
    localparam int unsigned SEL_W  = $clog2(NSETS),
    localparam int unsigned ADDR_W = BIDX_W + SEL_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SEL_W-1:0]          set_sel,
    input  logic signed [DATA_W-1:0]  in_a,
    input  logic signed [DATA_W-1:0]  in_b,
    input  logic signed [DATA_W-1:0]  in_c,
    input  logic [WIN_W-1:0]          win_lsb,
    input  logic                      cfg_we,
    input  logic [ADDR_W-1:0]         cfg_addr,
    input  logic [COEF_W-1:0]         cfg_wdata,
    output logic signed [DATA_W-1:0]  out_a,
    output logic signed [DATA_W-1:0]  out_b,
    output logic signed [DATA_W-1:0]  out_c
);
    localparam int unsigned NCH   = CMX_NCH;
    localparam int unsigned NBANK = CMX_NBANK;

    typedef struct packed {
        logic [SEL_W-1:0]                  sel1;  // stage 1
        logic [NCH-1:0][DATA_W-1:0]        x1;
        logic [NCH-1:0][DATA_W-1:0]        x2;    // stage 2
        logic [NBANK-1:0][COEF_W-1:0]      k2;
    } front_t;

    front_t st_d, st_q;

    logic [NBANK-1:0][NSETS-1:0][COEF_W-1:0] coef_store;
    logic [NCH-1:0][MID_W-1:0]               mid;
    logic [NCH-1:0][DATA_W-1:0]              res;

    cmx_coef_store #(
        .COEF_W (COEF_W),
        .NSETS  (NSETS),
        .NBANK  (NBANK),
        .BIDX_W (BIDX_W),
        .SEL_W  (SEL_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .bidx_i  (cfg_addr[ADDR_W-1:SEL_W]),
        .set_i   (cfg_addr[SEL_W-1:0]),
        .wdata_i (cfg_wdata),
        .store_o (coef_store)
    );

    always_comb begin
        st_d       = st_q;
        st_d.sel1  = set_sel;
        st_d.x1[0] = in_a;
        st_d.x1[1] = in_b;
        st_d.x1[2] = in_c;
        st_d.x2    = st_q.x1;
        // The set index travels with its samples into the lookup stage.
        for (int b = 0; b < int'(NBANK); b++) begin
            st_d.k2[b] = coef_store[b][st_q.sel1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar r = 0; r < NCH; r++) begin : g_row
        cmx_dot3 #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .MID_W  (MID_W)
        ) u_dot (
            .clk   (clk),
            .rst_n (rst_n),
            .x_i   (st_q.x2),
            .k_i   (st_q.k2[cmx_bank_of(r, 0) +: NCH]),
            .mid_o (mid[r])
        );

        cmx_rsl #(
            .MID_W  (MID_W),
            .DATA_W (DATA_W),
            .WIN_W  (WIN_W)
        ) u_rsl (
            .clk   (clk),
            .rst_n (rst_n),
            .mid_i (mid[r]),
            .win_i (win_lsb),
            .res_o (res[r])
        );
    end

    assign out_a = res[0];
    assign out_b = res[1];
    assign out_c = res[2];
endmodule

// File: rtl/cmx_checker.sv
`timescale 1ns/1ps
module cmx_checker #(
    parameter int unsigned DATA_W = 13,
    parameter int unsigned COEF_W = 13,
    parameter int unsigned NSETS  = 4,
    parameter int unsigned NBANK  = 9,
    parameter int unsigned BIDX_W = 4,
    parameter int unsigned SEL_W  = 2
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic [DATA_W-1:0]                        in_a,
    input logic [DATA_W-1:0]                        in_b,
    input logic [DATA_W-1:0]                        in_c,
    input logic [DATA_W-1:0]                        out_a,
    input logic [DATA_W-1:0]                        out_b,
    input logic [DATA_W-1:0]                        out_c,
    input logic                                     cfg_we,
    input logic [BIDX_W+SEL_W-1:0]                  cfg_addr,
    input logic [COEF_W-1:0]                        cfg_wdata,
    input logic [NBANK-1:0][NSETS-1:0][COEF_W-1:0]  coef_store
);
    logic [3:0]        since_rst;
    logic [BIDX_W-1:0] bidx;
    logic [SEL_W-1:0]  bset;
    logic              outs_zero;

    assign bidx      = cfg_addr[BIDX_W+SEL_W-1:SEL_W];
    assign bset      = cfg_addr[SEL_W-1:0];
    assign outs_zero = (out_a == '0) && (out_b == '0) && (out_c == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != 4'hF)  since_rst <= since_rst + 4'd1;
    end

    // R1: pipeline drains zeros for five edges after release.
    p_settle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst <= 4'd5) |-> outs_zero);

    // R2 and R7: zero inputs six edges ago give zero outputs now.
    p_zero_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 4'd7) && ($past(in_a, 6) == '0) && ($past(in_b, 6) == '0)
         && ($past(in_c, 6) == '0)) |-> outs_zero);

    // R4: a valid write lands in the addressed bank and set.
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(bidx) < int'(NBANK)))
        |=> (coef_store[$past(bidx)][$past(bset)] == $past(cfg_wdata)));

    // R4: no strobe, no change.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(coef_store));

    // R5: out-of-range bank numbers touch nothing.
    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (int'(bidx) >= int'(NBANK))) |=> $stable(coef_store));
endmodule

bind color_matrix_xform cmx_checker #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .NSETS  (NSETS),
    .NBANK  (NBANK),
    .BIDX_W (BIDX_W),
    .SEL_W  (SEL_W)
) u_cmx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_c       (in_c),
    .out_a      (out_a),
    .out_b      (out_b),
    .out_c      (out_c),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .coef_store (coef_store)
);

// File: tb/color_matrix_xform_tb_top.sv
`timescale 1ns/1ps
module color_matrix_xform_tb_top;
    localparam int NVEC = 12;
    // Columns: set, in_a, in_b, in_c, exp_a, exp_b, exp_c (window at 3).
    localparam int VEC [NVEC][7] = '{
        '{0,   100,  -200,   300,   100,  -200,   300},  // R3 identity
        '{1,   100,  -200,   300,   300,   100,  -200},  // R4 permutation set
        '{2,     1,     0,     0,     1,     1,     1},  // R8 +0.5 rounds up
        '{2,    -1,     0,     0,     0,     0,     0},  // R8 -0.5 rounds up
        '{2,     3,     0,     0,     2,     2,     2},  // R8 1.5 -> 2
        '{2,    -3,     0,     0,    -1,    -1,    -1},  // R8 -1.5 -> -1
        '{2,  4095,  4095,  4095,  4095,  4095,  4095},  // R9 high clamp
        '{2, -4096, -4096, -4096, -4096, -4096, -4096},  // R9 low clamp
        '{3, -4096,  4095,     0,  4095, -4095,     0},  // R9 negate full scale
        '{0, -4096,  4095,    -1, -4096,  4095,    -1},  // R3 extremes pass
        '{3,     7,    -7,     1,    -7,     7,    -1},  // R6 set switch
        '{1,     0,     0,    -5,    -5,     0,     0}   // R6 set switch
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [1:0]         set_sel = '0;
    logic signed [12:0] in_a = '0, in_b = '0, in_c = '0;
    logic [2:0]         win_lsb = 3'd3;
    logic               cfg_we = 1'b0;
    logic [5:0]         cfg_addr = '0;
    logic [12:0]        cfg_wdata = '0;
    logic signed [12:0] out_a, out_b, out_c;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    color_matrix_xform dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_sel   (set_sel),
        .in_a      (in_a),
        .in_b      (in_b),
        .in_c      (in_c),
        .win_lsb   (win_lsb),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .out_a     (out_a),
        .out_b     (out_b),
        .out_c     (out_c)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk3(input string req, input int ea, input int eb, input int ec);
        chk(req, int'(out_a), ea);
        chk(req, int'(out_b), eb);
        chk(req, int'(out_c), ec);
    endtask

    task automatic drive(input int s, input int a, input int b, input int c);
        set_sel = 2'(s);
        in_a    = 13'(a);
        in_b    = 13'(b);
        in_c    = 13'(c);
    endtask

    task automatic wr(input int bank, input int s, input int val);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 6'((bank << 2) | s);
        cfg_wdata = 13'(val);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Push one sample and read it back six edges later.
    task automatic one_shot(input string req, input int s, input int a, input int b,
                            input int c, input int ea, input int eb, input int ec);
        @(negedge clk);
        drive(s, a, b, c);
        @(negedge clk);
        drive(0, 0, 0, 0);
        repeat (5) @(negedge clk);
        chk3(req, ea, eb, ec);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk3("R1 outputs in reset", 0, 0, 0);
        drive(0, 11, 22, 33);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk3("R1 zero after release", 0, 0, 0);
        end
        drive(0, 0, 0, 0);

        // R4: load the four matrices.
        for (int r = 0; r < 3; r++) begin
            wr(r * 3 + r, 0, 'h0800);              // set 0: identity
            wr(r * 3 + ((r + 2) % 3), 1, 'h0800);  // set 1: a->b->c->a rotation
            wr(r * 3 + r, 3, 'h1800);              // set 3: negation
            for (int c = 0; c < 3; c++) wr(r * 3 + c, 2, 'h0400);  // set 2: halves
        end

        // R6: stream with a new set on every cycle.
        for (int i = 0; i < NVEC + 6; i++) begin
            @(negedge clk);
            if (i >= 6) chk3("R2/R6 stream", VEC[i-6][4], VEC[i-6][5], VEC[i-6][6]);
            if (i < NVEC) drive(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            else          drive(0, 0, 0, 0);
        end

        // R7: exact latency of one isolated sample.
        @(negedge clk);
        drive(0, 50, 60, 70);
        @(negedge clk);
        drive(0, 0, 0, 0);
        for (int k = 1; k <= 6; k++) begin
            if (k < 6) chk3("R7 not yet", 0, 0, 0);
            else       chk3("R7 at six", 50, 60, 70);
            if (k < 6) @(negedge clk);
        end

        // R5: writes to banks 9..15 must not alias onto real banks.
        wr(9, 0, 'h0400);
        wr(12, 0, 'h1000);
        wr(15, 0, 'h0400);
        one_shot("R5 ignored write", 0, 100, -100, 7, 100, -100, 7);

        // R8: other window positions.
        win_lsb = 3'd0;
        repeat (7) @(negedge clk);
        one_shot("R8 window 0", 0, 5, -5, 1, 40, -40, 8);
        one_shot("R9 window 0 clip", 0, 4095, -4096, 600, 4095, -4096, 4095);
        win_lsb = 3'd4;
        repeat (7) @(negedge clk);
        one_shot("R8 window 4", 0, 5, -5, 1, 3, -2, 1);
        win_lsb = 3'd7;
        repeat (7) @(negedge clk);
        one_shot("R8 window 7", 0, 4095, -4096, 64, 256, -256, 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule